// File: doc/BRIEF.md
# Priority Interrupt Level Resolver

This block sits between a set of external interrupt-level lines, a soft-interrupt register and the trap logic of a processor core. It keeps a vector of raised level lines, which is updated by raise and lower events. It merges that vector with the soft-interrupt bits into one pending-level vector and selects the highest pending level. It then proposes a trap code for the core: a fixed external-interrupt type base with the winning level in its low four bits.

The core returns its current pending-trap code on `cur_code`. The resolver installs a new code only into an empty slot or over an earlier external-interrupt code. It does not displace a pending trap of any other kind. A one-cycle request pulse tells the core to latch `trap_code` and take a hard interrupt. A one-cycle clear pulse tells the core to drop its external-interrupt code when nothing is pending any more. Evaluation runs on the clock after any line event, any change of the soft bits, or any change of `cur_code`.

Top module: `pil_resolver`

## Requirements
- R1: After reset, `trap_code` is 0, `req_pulse` and `clr_pulse` are low, and no level line is held raised.
- R2: An event with `evt_vld` high, `evt_raise` high and index k (1..15) raises line k. The same event with `evt_raise` low lowers line k. An event with index 0 is ignored.
- R3: Soft bits 1..15 count as pending at their own level. Soft bit 0, the timer bit, counts as pending at level 14 and never at level 0.
- R4: The winner is the highest pending level, scanned from 15 down to 1. Level 0 is never selected.
- R5: The proposed code is the external base (default 0x040) ORed with the 4-bit winning level.
- R6: A code is proposed only when `cur_code` is 0, or when `cur_code` bits above bit 3 equal the base's. A pending trap of any other kind is never overridden, and it is reconsidered when `cur_code` changes.
- R7: `req_pulse` fires only when the proposed code differs from `cur_code`. An equal code produces no pulse.
- R8: When nothing is pending and `cur_code` is an external-interrupt code, `clr_pulse` fires and `trap_code` becomes 0. Request and clear never fire together.
- R9: Outputs respond on the second rising edge after an input change is presented: the change is captured on the first edge and the outputs are registered on the second. Each pulse lasts one cycle, and `trap_code` holds between pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_vld | input | 1 | Level-line event strobe |
| evt_idx | input | 4 | Level line addressed by the event |
| evt_raise | input | 1 | 1 raises the line, 0 lowers it |
| soft_bits | input | 16 | Soft-interrupt register value; bit 0 is the timer bit |
| cur_code | input | 9 | Trap code currently pending in the core |
| trap_code | output | 9 | Code to install, valid with a pulse |
| req_pulse | output | 1 | Hard-interrupt request, one cycle |
| clr_pulse | output | 1 | Withdraw the external-interrupt code, one cycle |

## Verification
The checker watches every cycle for the following. A request must carry the external base and a non-zero level. It must differ from the code the core held and must land only in an empty or external-interrupt slot. A clear must zero the code and act only on an external-interrupt code. The two pulses must never coincide, and the code must stay stable between pulses. Only the directed scenarios can show which level wins for a given mix of lines and soft bits: the timer remap to level 14, the masking of line 0, and re-evaluation when a foreign trap is retired. The bench models the core by feeding each installed code back on `cur_code`.

// File: rtl/pil_pkg.sv
package pil_pkg;
  typedef enum logic [1:0] {
    ACT_NONE = 2'd0,
    ACT_SET  = 2'd1,
    ACT_CLR  = 2'd2
  } pil_act_e;
endpackage

// File: rtl/pil_level_reg.sv
module pil_level_reg #(
  parameter int NUM_LVL = 16,
  localparam int IDX_W = $clog2(NUM_LVL)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               evt_vld,
  input  logic [IDX_W-1:0]   evt_idx,
  input  logic               evt_raise,
  output logic [NUM_LVL-1:0] lvl_q
);
  logic [NUM_LVL-1:0] lvl_d;
  logic               lvl_en;

  // index 0 names no real line and leaves the vector untouched
  assign lvl_en = evt_vld && (evt_idx != '0);

  always_comb begin
    lvl_d = lvl_q;
    lvl_d[evt_idx] = evt_raise;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      lvl_q <= '0;
    else if (lvl_en) lvl_q <= lvl_d;
  end
endmodule

// File: rtl/pil_change_detect.sv
module pil_change_detect #(
  parameter int NUM_LVL = 16,
  parameter int CODE_W  = 9
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               evt_vld,
  input  logic [NUM_LVL-1:0] soft_bits,
  input  logic [CODE_W-1:0]  cur_code,
  output logic [NUM_LVL-1:0] soft_q,
  output logic               eval_q
);
  logic [CODE_W-1:0] cur_q;
  logic              trig;

  assign trig = evt_vld || (soft_bits != soft_q) || (cur_code != cur_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      soft_q <= '0;
      cur_q  <= '0;
      eval_q <= 1'b0;
    end else begin
      soft_q <= soft_bits;
      cur_q  <= cur_code;
      eval_q <= trig;
    end
  end
endmodule

// File: rtl/pil_prio_sel.sv
module pil_prio_sel #(
  parameter int NUM_LVL   = 16,
  parameter int TIMER_LVL = 14,
  localparam int IDX_W = $clog2(NUM_LVL)
) (
  input  logic [NUM_LVL-1:0] lvl_vec,
  input  logic [NUM_LVL-1:0] soft_vec,
  output logic               any_pend,
  output logic [IDX_W-1:0]   win_lvl
);
  logic [NUM_LVL-1:0] pend;

  always_comb begin
    pend = lvl_vec | {soft_vec[NUM_LVL-1:1], 1'b0};
    pend[TIMER_LVL] = pend[TIMER_LVL] | soft_vec[0];
  end

  assign any_pend = |pend[NUM_LVL-1:1];

  // ascending scan, so the highest set level is the last one written
  always_comb begin
    win_lvl = '0;
    for (int i = 1; i < NUM_LVL; i++) begin
      if (pend[i]) win_lvl = IDX_W'(i);
    end
  end
endmodule

// File: rtl/pil_resolver.sv
module pil_resolver #(
  parameter int                NUM_LVL   = 16,
  parameter int                CODE_W    = 9,
  parameter int                TIMER_LVL = 14,
  parameter logic [CODE_W-1:0] EXT_BASE  = 9'h040,
  localparam int IDX_W = $clog2(NUM_LVL)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               evt_vld,
  input  logic [IDX_W-1:0]   evt_idx,
  input  logic               evt_raise,
  input  logic [NUM_LVL-1:0] soft_bits,
  input  logic [CODE_W-1:0]  cur_code,
  output logic [CODE_W-1:0]  trap_code,
  output logic               req_pulse,
  output logic               clr_pulse
);
  import pil_pkg::*;

  logic [NUM_LVL-1:0] lvl_q;
  logic [NUM_LVL-1:0] soft_q;
  logic               eval_q;
  logic               any_pend;
  logic [IDX_W-1:0]   win_lvl;
  logic [CODE_W-1:0]  cand;
  logic               cur_ext;
  logic               slot_free;
  pil_act_e           act;
  logic [CODE_W-1:0]  code_d;

  pil_level_reg #(.NUM_LVL(NUM_LVL)) u_lvl (
    .clk(clk), .rst_n(rst_n), .evt_vld(evt_vld), .evt_idx(evt_idx),
    .evt_raise(evt_raise), .lvl_q(lvl_q)
  );

  pil_change_detect #(.NUM_LVL(NUM_LVL), .CODE_W(CODE_W)) u_chg (
    .clk(clk), .rst_n(rst_n), .evt_vld(evt_vld), .soft_bits(soft_bits),
    .cur_code(cur_code), .soft_q(soft_q), .eval_q(eval_q)
  );

  pil_prio_sel #(.NUM_LVL(NUM_LVL), .TIMER_LVL(TIMER_LVL)) u_sel (
    .lvl_vec(lvl_q), .soft_vec(soft_q), .any_pend(any_pend), .win_lvl(win_lvl)
  );

  assign cand      = EXT_BASE | {{(CODE_W-IDX_W){1'b0}}, win_lvl};
  assign cur_ext   = cur_code[CODE_W-1:IDX_W] == EXT_BASE[CODE_W-1:IDX_W];
  assign slot_free = (cur_code == '0) || cur_ext;

  always_comb begin
    act    = ACT_NONE;
    code_d = trap_code;
    if (eval_q) begin
      if (any_pend && slot_free && (cand != cur_code)) begin
        act    = ACT_SET;
        code_d = cand;
      end else if (!any_pend && cur_ext) begin
        act    = ACT_CLR;
        code_d = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trap_code <= '0;
      req_pulse <= 1'b0;
      clr_pulse <= 1'b0;
    end else begin
      req_pulse <= (act == ACT_SET);
      clr_pulse <= (act == ACT_CLR);
      if (act != ACT_NONE) trap_code <= code_d;
    end
  end
endmodule

// File: rtl/pil_resolver_chk.sv
module pil_resolver_chk #(
  parameter int                CODE_W   = 9,
  parameter int                IDX_W    = 4,
  parameter logic [CODE_W-1:0] EXT_BASE = 9'h040
) (
  input logic              clk,
  input logic              rst_n,
  input logic [CODE_W-1:0] cur_code,
  input logic [CODE_W-1:0] trap_code,
  input logic              req_pulse,
  input logic              clr_pulse
);
  AST_REQ_CLR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({req_pulse, clr_pulse})); // R8
  AST_REQ_EXT_BASE: assert property (@(posedge clk) disable iff (!rst_n)
    req_pulse |-> trap_code[CODE_W-1:IDX_W] == EXT_BASE[CODE_W-1:IDX_W]); // R5
  AST_REQ_LVL_NZ: assert property (@(posedge clk) disable iff (!rst_n)
    req_pulse |-> trap_code[IDX_W-1:0] != '0); // R4
  AST_REQ_DIFFERS: assert property (@(posedge clk) disable iff (!rst_n)
    req_pulse |-> trap_code != $past(cur_code)); // R7
  AST_REQ_SLOT_OK: assert property (@(posedge clk) disable iff (!rst_n)
    req_pulse |-> ($past(cur_code) == '0 ||
      $past(cur_code[CODE_W-1:IDX_W]) == EXT_BASE[CODE_W-1:IDX_W])); // R6
  AST_CLR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    clr_pulse |-> trap_code == '0); // R8
  AST_CLR_EXT_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    clr_pulse |-> $past(cur_code[CODE_W-1:IDX_W]) == EXT_BASE[CODE_W-1:IDX_W]); // R8
  AST_CODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_pulse && !clr_pulse) |-> $stable(trap_code)); // R9
endmodule

bind pil_resolver pil_resolver_chk #(
  .CODE_W(CODE_W), .IDX_W(IDX_W), .EXT_BASE(EXT_BASE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cur_code(cur_code), .trap_code(trap_code),
  .req_pulse(req_pulse), .clr_pulse(clr_pulse)
);

// File: tb/pil_resolver_tb.sv
`timescale 1ns/1ps
module pil_resolver_tb;
  logic        clk;
  logic        rst_n;
  logic        evt_vld;
  logic [3:0]  evt_idx;
  logic        evt_raise;
  logic [15:0] soft_bits;
  logic [8:0]  cur_code;
  logic [8:0]  trap_code;
  logic        req_pulse;
  logic        clr_pulse;
  int checks;
  int errors;

  pil_resolver u_dut (
    .clk(clk), .rst_n(rst_n), .evt_vld(evt_vld), .evt_idx(evt_idx),
    .evt_raise(evt_raise), .soft_bits(soft_bits), .cur_code(cur_code),
    .trap_code(trap_code), .req_pulse(req_pulse), .clr_pulse(clr_pulse)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // outputs after a stimulus: req, clr, and code (code checked when req/clr)
  task automatic expect_out(input bit er, input bit ec, input int code, input string tag);
    chk(req_pulse == er, {tag, " req"}, req_pulse, er);
    chk(clr_pulse == ec, {tag, " clr"}, clr_pulse, ec);
    if (er || ec) chk(trap_code == code, {tag, " code"}, trap_code, code);
  endtask

  // drive at a falling edge, capture on the next rise, outputs on the one after
  task automatic line_evt(input int idx, input bit up);
    @(negedge clk);
    evt_vld = 1'b1; evt_idx = 4'(idx); evt_raise = up;
    @(negedge clk);
    evt_vld = 1'b0;
    @(negedge clk);
  endtask

  task automatic set_soft(input logic [15:0] v);
    @(negedge clk); soft_bits = v;
    @(negedge clk); @(negedge clk);
  endtask

  // core model: latch a code, then confirm the resolver stays quiet
  task automatic set_cur(input logic [8:0] v, input string tag);
    @(negedge clk); cur_code = v;
    @(negedge clk); @(negedge clk);
    expect_out(0, 0, 0, tag);
  endtask

  task automatic t_reset();
    chk(trap_code == 0, "R1 code", trap_code, 0);
    chk(!req_pulse && !clr_pulse, "R1 pulses", {req_pulse, clr_pulse}, 0);
  endtask

  task automatic t_lines();
    line_evt(5, 1);
    expect_out(1, 0, 'h45, "R2 R5 raise 5");
    @(negedge clk);
    chk(req_pulse == 0, "R9 pulse width", req_pulse, 0);
    chk(trap_code == 'h45, "R9 code hold", trap_code, 'h45);
    set_cur('h45, "R7 equal after install");
    line_evt(3, 1);
    expect_out(0, 0, 0, "R4 R7 lower level no change");
    line_evt(9, 1);
    expect_out(1, 0, 'h49, "R4 higher wins");
    set_cur('h49, "R7 settle 49");
    line_evt(9, 0);
    expect_out(1, 0, 'h45, "R2 lower 9");
    set_cur('h45, "R7 settle 45");
  endtask

  task automatic t_soft();
    set_soft(16'h0001);
    expect_out(1, 0, 'h4E, "R3 timer to 14");
    set_cur('h4E, "R7 settle 4E");
    set_soft(16'h8001);
    expect_out(1, 0, 'h4F, "R3 R4 soft 15");
    set_cur('h4F, "R7 settle 4F");
    set_soft(16'h0000);
    expect_out(1, 0, 'h45, "R3 soft drop");
    set_cur('h45, "R7 settle 45b");
  endtask

  task automatic t_clear();
    line_evt(3, 0);
    expect_out(0, 0, 0, "R4 drop lower line");
    line_evt(5, 0);
    expect_out(0, 1, 0, "R8 clear when empty");
    set_cur('h000, "R8 settle 0");
    line_evt(0, 1);
    expect_out(0, 0, 0, "R2 R4 index 0 ignored");
    set_soft(16'h0002);
    expect_out(1, 0, 'h41, "R3 R4 soft 1");
    set_cur('h41, "R7 settle 41");
    set_soft(16'h0000);
    expect_out(0, 1, 0, "R2 R8 clear with line 0");
    set_cur('h000, "R8 settle 0b");
  endtask

  task automatic t_foreign();
    set_cur('h0A3, "R6 foreign installed");
    line_evt(7, 1);
    expect_out(0, 0, 0, "R6 no override");
    line_evt(7, 0);
    expect_out(0, 0, 0, "R8 no clear on foreign");
    line_evt(7, 1);
    expect_out(0, 0, 0, "R6 still blocked");
    @(negedge clk); cur_code = 9'h000;
    @(negedge clk); @(negedge clk);
    expect_out(1, 0, 'h47, "R6 reeval on retire");
    set_cur('h47, "R7 settle 47");
  endtask

  initial begin
    checks = 0; errors = 0;
    rst_n = 1'b0; evt_vld = 1'b0; evt_idx = '0; evt_raise = 1'b0;
    soft_bits = '0; cur_code = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_lines();
    t_soft();
    t_clear();
    t_foreign();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual 0x%0h expected 0x%0h", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule